// File: doc/BRIEF.md
# Buffered Program-Flash Block Writer

This block sits between a CPU's register writes and a word-addressed program flash. Software programs the flash one word at a time. It loads a target address and a data word. It then writes the two-byte unlock key to the key register and sets the start bit in the control register. The key is 0x55 followed by 0xAA, and these must be the last two register writes before the start write.

Words are staged into an eight-slot buffer that belongs to one aligned eight-word block. Slots must be filled in ascending order. A word that lands in any slot except the last completes after a short setup delay, and the CPU does not stall. A word that lands in the last slot (address low bits 111) starts the commit. The controller erases the aligned sixteen-word region that holds the block, then programs all eight buffered words. For the whole commit it holds a CPU stall output. The upper half of a sixteen-word region is written by repeating the eight-word sequence.

Every start request is checked against the unlock key, the program-memory select bit, a two-bit write-protection setting and the slot order. A request that fails any check changes nothing and raises a sticky error flag. Erase and program durations are set by parameters in clock cycles.

Top module: `flash_blkwr_ctrl`

## Requirements
- R1: A start request is honoured only when the two register writes just before it were key-register writes of 0x55 and then 0xAA. Any other write in between breaks the key, including a different key byte or a write to another register. A request without the key is rejected.
- R2: A start request is rejected unless control bit 1 (program-memory select) is 1 in the same control write that sets bit 0 (start).
- R3: A start request is rejected when the target address is write-protected. The protected range depends on prot_cfg: 2'b11 protects nothing, 2'b10 protects addresses below 1/32 of the array, 2'b01 protects below 1/4, and 2'b00 protects below 1/2.
- R4: The slot is given by address bits [2:0] and must equal the next expected slot, counting 0 through 7. Slot 0 opens a block. Slots 1 to 7 must share slot 0's address bits above bit 2. A request that breaks either rule is rejected.
- R5: An accepted word in slots 0 to 6 holds wr_busy high for exactly SETUP_CYC cycles. It never raises cpu_stall and makes no flash access. It only stores the data word (the low DATA_W bits of the data register) in that slot.
- R6: An accepted word in slot 7 first pulses fl_erase for one cycle, with fl_addr set to the sixteen-word-aligned region base. The region is expected to read back all ones afterwards. The block then drives fl_we for eight cycles, writing the buffered slots 0 to 7 at the block base plus 0 to 7 in ascending order.
- R7: For a slot-7 word, cpu_stall is high for exactly ERASE_CYC+8 cycles and wr_busy for exactly SETUP_CYC+ERASE_CYC+8 cycles. After that both drop together, and the next block starts at slot 0.
- R8: wr_err is set by any rejected start request. It stays set until a control write with bit 2 = 1 (error clear). It stays set through later accepted requests.
- R9: Every register write (register select 0 = address, 1 = data, 2 = control, 3 = key) made while wr_busy is high is dropped.
- R10: After reset, wr_busy, cpu_stall, wr_err, fl_erase and fl_we are all 0, and the next expected slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | CPU register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| reg_wdata | input | REG_W | Register write data |
| prot_cfg | input | 2 | Write-protection setting |
| wr_busy | output | 1 | Start bit readback, high while a request is in progress |
| cpu_stall | output | 1 | Halts CPU execution during erase and program |
| wr_err | output | 1 | Sticky rejected-request flag |
| fl_erase | output | 1 | One-cycle erase pulse for a sixteen-word region |
| fl_we | output | 1 | Flash word program strobe |
| fl_addr | output | ADDR_W | Flash address for erase or program |
| fl_wdata | output | DATA_W | Flash program data |

## Verification
Two events can meet in one cycle: the end of an accepted request and a new CPU register write. In the cycle where wr_busy is about to fall, the bench writes a new data value. That write must be dropped. The bench then loads the next slot without rewriting the data register, commits the block, and reads the flash model. The slot must hold the earlier data word, not the value written late. A second case meets in the same control write: it sets both the error-clear bit and a start bit that is rejected. The set must win over the clear.

// File: rtl/fbw_pkg.sv
// Shared types and constants for the flash block writer.
// Assumes the register select encoding is fixed by the CPU-side decoder.
package fbw_pkg;
    typedef enum logic [1:0] {
        RS_ADDR = 2'd0,
        RS_DATA = 2'd1,
        RS_CTRL = 2'd2,
        RS_KEY  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ERASE = 2'd2,
        ST_PROG  = 2'd3
    } seq_st_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int CTRL_START = 0;
    localparam int CTRL_PSEL  = 1;
    localparam int CTRL_ECLR  = 2;
endpackage

// File: rtl/fbw_key_seq.sv
// Unlock key tracker: arms after a write of 0x55 to the key register that is
// immediately followed by a write of 0xAA. Any other accepted register write,
// including the control write that uses the key, disarms it.
// Assumes wr_en already excludes writes that the caller drops.
module fbw_key_seq
    import fbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       is_key,
    input  logic [7:0] wdata,
    output logic       armed
);
    logic half_q;
    logic armed_q;

    // Step through the two-byte key on every accepted register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (wr_en) begin
            if (is_key && wdata == KEY_FIRST) begin
                half_q  <= 1'b1;
                armed_q <= 1'b0;
            end else if (is_key && wdata == KEY_SECOND && half_q) begin
                half_q  <= 1'b0;
                armed_q <= 1'b1;
            end else begin
                half_q  <= 1'b0;
                armed_q <= 1'b0;
            end
        end
    end

    assign armed = armed_q;

    // R1: arming can only follow a write of the second key byte.
    a_r1_arm_after_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(wr_en && is_key && wdata == KEY_SECOND));
endmodule

// File: rtl/fbw_prot_guard.sv
// Write-protection decode: flags an address that lies in the protected low
// segment chosen by a two-bit setting (11 none, 10 1/32, 01 1/4, 00 1/2).
// Assumes the protected segment always starts at address zero.
module fbw_prot_guard #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam longint DEPTH = 64'd1 << ADDR_W;
    localparam logic [ADDR_W:0] LIM_HALF    = (ADDR_W+1)'(DEPTH >> 1);
    localparam logic [ADDR_W:0] LIM_QUARTER = (ADDR_W+1)'(DEPTH >> 2);
    localparam logic [ADDR_W:0] LIM_32ND    = (ADDR_W+1)'(DEPTH >> 5);

    logic [ADDR_W:0] limit;

    // Pick the upper bound of the protected segment.
    always_comb begin
        case (cfg)
            2'b00:   limit = LIM_HALF;
            2'b01:   limit = LIM_QUARTER;
            2'b10:   limit = LIM_32ND;
            default: limit = '0;
        endcase
    end

    assign locked = {1'b0, addr} < limit;
endmodule

// File: rtl/fbw_word_buf.sv
// Eight-slot (DEPTH) staging buffer for one aligned program block.
// One write port and one combinational read port; cleared by reset.
module fbw_word_buf #(
    parameter int DATA_W = 14,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    // Store one word into the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (we) begin
            slot_q[widx] <= wdata;
        end
    end

    assign rdata = slot_q[ridx];
endmodule

// File: rtl/flash_blkwr_ctrl.sv
// Buffered program-flash block writer. It takes address, data, control and
// key register writes from a CPU. Each request is checked for a valid key,
// the program select bit, write protection and slot order. Slots 0..6 are
// staged into the buffer; slot 7 erases the sixteen-word region and programs
// the block while stalling the CPU.
// Assumes a flash model that clears a region on fl_erase and stores a word on fl_we.
module flash_blkwr_ctrl
    import fbw_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 14,
    parameter int REG_W     = 16,
    parameter int BLK_WORDS = 8,
    parameter int SETUP_CYC = 2,
    parameter int ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [1:0]        prot_cfg,
    output logic              wr_busy,
    output logic              cpu_stall,
    output logic              wr_err,
    output logic              fl_erase,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata
);
    localparam int SLOT_W   = $clog2(BLK_WORDS);
    localparam int REGION_W = SLOT_W + 1;
    localparam int UPPER_W  = ADDR_W - SLOT_W;
    localparam int CNT_W    = $clog2(SETUP_CYC + ERASE_CYC + BLK_WORDS + 1);

    reg_sel_e            sel;
    seq_st_e             st_q;
    logic                busy_q, err_q, acc_we, armed, locked;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q, buf_rdata;
    logic [CNT_W-1:0]    cnt_q;
    logic [SLOT_W-1:0]   nxt_slot_q, slot_w;
    logic [UPPER_W-1:0]  blk_base_q, upper_w;
    logic                start_req, clr_req, order_ok, start_ok, start_bad;
    logic                last_step, is_last;

    assign sel     = reg_sel_e'(reg_sel);
    assign acc_we  = reg_we && !busy_q;
    assign slot_w  = addr_q[SLOT_W-1:0];
    assign upper_w = addr_q[ADDR_W-1:SLOT_W];
    assign is_last = (slot_w == {SLOT_W{1'b1}});

    assign start_req = acc_we && sel == RS_CTRL && reg_wdata[CTRL_START];
    assign clr_req   = acc_we && sel == RS_CTRL && reg_wdata[CTRL_ECLR];
    assign order_ok  = (slot_w == nxt_slot_q) &&
                       (nxt_slot_q == '0 || upper_w == blk_base_q);
    assign start_ok  = start_req && armed && reg_wdata[CTRL_PSEL] &&
                       !locked && order_ok;
    assign start_bad = start_req && !start_ok;
    assign last_step = (st_q == ST_SETUP) && (cnt_q == CNT_W'(SETUP_CYC - 1));

    fbw_key_seq u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (acc_we),
        .is_key (sel == RS_KEY),
        .wdata  (reg_wdata[7:0]),
        .armed  (armed)
    );

    fbw_prot_guard #(.ADDR_W(ADDR_W)) u_prot (
        .cfg    (prot_cfg),
        .addr   (addr_q),
        .locked (locked)
    );

    fbw_word_buf #(.DATA_W(DATA_W), .DEPTH(BLK_WORDS)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (last_step),
        .widx   (slot_w),
        .wdata  (data_q),
        .ridx   (cnt_q[SLOT_W-1:0]),
        .rdata  (buf_rdata)
    );

    // Capture address and data register writes when not busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (acc_we) begin
            if (sel == RS_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
            if (sel == RS_DATA) data_q <= reg_wdata[DATA_W-1:0];
        end
    end

    // Sticky error flag: a rejected request sets it, the clear bit drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (start_bad) err_q <= 1'b1;
        else if (clr_req)   err_q <= 1'b0;
    end

    // Slot order tracking: next expected slot and the open block's upper address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_slot_q <= '0;
            blk_base_q <= '0;
        end else if (last_step) begin
            nxt_slot_q <= slot_w + 1'b1;
            if (slot_w == '0) blk_base_q <= upper_w;
        end
    end

    // Sequencer: setup delay, then region erase and block program for slot 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (start_ok) begin
                    st_q   <= ST_SETUP;
                    cnt_q  <= '0;
                    busy_q <= 1'b1;
                end
                ST_SETUP: if (last_step) begin
                    cnt_q <= '0;
                    if (is_last) begin
                        st_q <= ST_ERASE;
                    end else begin
                        st_q   <= ST_IDLE;
                        busy_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_ERASE: if (cnt_q == CNT_W'(ERASE_CYC - 1)) begin
                    st_q  <= ST_PROG;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: if (cnt_q == CNT_W'(BLK_WORDS - 1)) begin
                    st_q   <= ST_IDLE;
                    cnt_q  <= '0;
                    busy_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            endcase
        end
    end

    assign wr_busy   = busy_q;
    assign wr_err    = err_q;
    assign cpu_stall = (st_q == ST_ERASE) || (st_q == ST_PROG);
    assign fl_erase  = (st_q == ST_ERASE) && (cnt_q == '0);
    assign fl_we     = (st_q == ST_PROG);
    assign fl_wdata  = buf_rdata;
    assign fl_addr   = fl_we ? {blk_base_q, cnt_q[SLOT_W-1:0]}
                             : {addr_q[ADDR_W-1:REGION_W], {REGION_W{1'b0}}};

    // R7: the CPU is only stalled while the start bit reads as set.
    a_r7_stall_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> wr_busy);
    // R5: finishing a slot 0..6 word leaves no stall and no busy behind.
    a_r5_short_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (last_step && !is_last) |=> (!cpu_stall && !wr_busy));
    // R6: every program strobe targets the block held in the address register.
    a_r6_prog_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> fl_addr[ADDR_W-1:SLOT_W] == addr_q[ADDR_W-1:SLOT_W]);
    // R6: an erase is issued only under stall and never together with a program.
    a_r6_erase_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        fl_erase |-> (cpu_stall && !fl_we));
    // R8: the error flag holds unless a clear request arrives.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_req) |=> err_q);
    // R9: register contents do not move while busy.
    a_r9_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: tb/sim_flash_blkwr_ctrl.sv
// Directed bench for flash_blkwr_ctrl with a small behavioural flash model.
module sim_flash_blkwr_ctrl;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 14;
    localparam int SETUP  = 2;
    localparam int ERASE  = 40;
    localparam logic [DATA_W-1:0] BLANK = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [15:0]       reg_wdata = '0;
    logic [1:0]        prot_cfg = 2'b11;
    logic              wr_busy, cpu_stall, wr_err, fl_erase, fl_we;
    logic [ADDR_W-1:0] fl_addr;
    logic [DATA_W-1:0] fl_wdata;

    logic [DATA_W-1:0] fm [1024];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    flash_blkwr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP),
                       .ERASE_CYC(ERASE)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .prot_cfg(prot_cfg), .wr_busy(wr_busy),
        .cpu_stall(cpu_stall), .wr_err(wr_err), .fl_erase(fl_erase),
        .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata)
    );

    // Flash model: erase clears a sixteen-word region, program stores a word.
    always @(posedge clk) begin
        if (fl_erase)
            for (int i = 0; i < 16; i++) fm[{fl_addr[9:4], 4'(i)}] = BLANK;
        if (fl_we) fm[fl_addr[9:0]] = fl_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [15:0] v);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle(output int busy_n, output int stall_n);
        busy_n = 0; stall_n = 0;
        while (wr_busy && busy_n < 2000) begin
            busy_n++;
            if (cpu_stall) stall_n++;
            @(negedge clk);
        end
    endtask

    task automatic do_word(input int a, input int d, input logic [15:0] ctrl,
                           output int busy_n, output int stall_n);
        wr_reg(2'd0, 16'(a));
        wr_reg(2'd1, 16'(d));
        wr_reg(2'd3, 16'h55);
        wr_reg(2'd3, 16'hAA);
        wr_reg(2'd2, ctrl);
        wait_idle(busy_n, stall_n);
    endtask

    task automatic clr_err();
        wr_reg(2'd2, 16'h4);
    endtask

    task automatic t_reset();
        chk(!wr_busy && !cpu_stall, "R10 busy/stall", {wr_busy, cpu_stall}, 0);
        chk(!wr_err, "R10 err", wr_err, 0);
        chk(!fl_erase && !fl_we, "R10 flash strobes", {fl_erase, fl_we}, 0);
    endtask

    task automatic t_full_block();
        int b, s;
        for (int i = 0; i < 16; i++) fm[16'h100 + i] = DATA_W'(16'h1111 + i);
        for (int i = 0; i < 8; i++) begin
            do_word(16'h100 + i, 16'h2000 + i, 16'h3, b, s);
            if (i < 7) begin
                chk(b == SETUP, "R5 busy length", b, SETUP);
                chk(s == 0, "R5 no stall", s, 0);
            end else begin
                chk(b == SETUP + ERASE + 8, "R7 busy length", b, SETUP + ERASE + 8);
                chk(s == ERASE + 8, "R7 stall length", s, ERASE + 8);
            end
            if (i == 6) chk(fm[16'h100] == 14'h1111, "R5 flash untouched", fm[16'h100], 14'h1111);
        end
        for (int i = 0; i < 8; i++)
            chk(fm[16'h100 + i] == DATA_W'(16'h2000 + i), "R6 programmed", fm[16'h100 + i], 16'h2000 + i);
        for (int i = 8; i < 16; i++)
            chk(fm[16'h100 + i] == BLANK, "R6 upper half erased", fm[16'h100 + i], BLANK);
        chk(!wr_err, "R6 no error", wr_err, 0);
    endtask

    task automatic t_unlock();
        int b, s;
        wr_reg(2'd0, 16'h110); wr_reg(2'd1, 16'h0B00);
        wr_reg(2'd3, 16'h55); wr_reg(2'd3, 16'h12); wr_reg(2'd3, 16'hAA);
        wr_reg(2'd2, 16'h3);
        chk(!wr_busy && wr_err, "R1 broken key rejected", {wr_busy, wr_err}, 1);
        clr_err();
        wr_reg(2'd3, 16'h55); wr_reg(2'd3, 16'hAA); wr_reg(2'd1, 16'h0B00);
        wr_reg(2'd2, 16'h3);
        chk(!wr_busy && wr_err, "R1 write after key rejected", {wr_busy, wr_err}, 1);
        clr_err();
        wr_reg(2'd3, 16'h55); wr_reg(2'd3, 16'h55); wr_reg(2'd3, 16'hAA);
        wr_reg(2'd2, 16'h3);
        chk(wr_busy == 1'b1, "R1 repeated first byte accepted", wr_busy, 1);
        wait_idle(b, s);
        for (int i = 1; i < 8; i++) do_word(16'h110 + i, 16'h0A00 + i, 16'h3, b, s);
        chk(fm[16'h110] == 14'h0B00, "R1 slot0 data", fm[16'h110], 14'h0B00);
        chk(fm[16'h117] == 14'h0A07, "R1 slot7 data", fm[16'h117], 14'h0A07);
        chk(!wr_err, "R1 clean run", wr_err, 0);
    endtask

    task automatic t_select();
        int b, s;
        do_word(16'h120, 16'h0C00, 16'h1, b, s);
        chk(b == 0 && wr_err, "R2 select bit clear rejected", b, 0);
        clr_err();
    endtask

    task automatic t_protect();
        int b, s;
        fm[16'h080] = 14'h0555;
        prot_cfg = 2'b10;
        do_word(16'h080, 16'h0111, 16'h3, b, s);
        chk(b == 0 && wr_err, "R3 protected low 1/32 rejected", b, 0);
        do_word(16'h120, 16'h0C00, 16'h3, b, s);
        chk(b == SETUP, "R3 address above 1/32 accepted", b, SETUP);
        chk(wr_err == 1'b1, "R8 error stays set", wr_err, 1);
        wr_reg(2'd2, 16'h5);
        chk(wr_err == 1'b1, "R8 set wins over clear", wr_err, 1);
        clr_err();
        chk(!wr_err, "R8 clear bit", wr_err, 0);
        prot_cfg = 2'b00;
        do_word(16'h121, 16'h0C01, 16'h3, b, s);
        chk(b == 0 && wr_err, "R3 protected low half rejected", b, 0);
        clr_err();
        prot_cfg = 2'b11;
        for (int i = 1; i < 8; i++) do_word(16'h120 + i, 16'h0C00 + i, 16'h3, b, s);
        chk(fm[16'h080] == 14'h0555, "R3 protected word unchanged", fm[16'h080], 14'h0555);
        chk(fm[16'h121] == 14'h0C01 && fm[16'h120] == 14'h0C00, "R3 block programmed", fm[16'h121], 14'h0C01);
    endtask

    task automatic t_order();
        int b, s;
        do_word(16'h140, 16'h0D00, 16'h3, b, s);
        do_word(16'h142, 16'h0EEE, 16'h3, b, s);
        chk(b == 0 && wr_err, "R4 skipped slot rejected", b, 0);
        clr_err();
        do_word(16'h149, 16'h0FFF, 16'h3, b, s);
        chk(b == 0 && wr_err, "R4 foreign block rejected", b, 0);
        clr_err();
        for (int i = 1; i < 8; i++) do_word(16'h140 + i, 16'h0D00 + i, 16'h3, b, s);
        chk(fm[16'h142] == 14'h0D02, "R4 slot2 data", fm[16'h142], 14'h0D02);
        chk(fm[16'h141] == 14'h0D01, "R4 slot1 data", fm[16'h141], 14'h0D01);
    endtask

    task automatic t_busy_drop();
        int b, s;
        wr_reg(2'd0, 16'h160); wr_reg(2'd1, 16'h0600);
        wr_reg(2'd3, 16'h55); wr_reg(2'd3, 16'hAA); wr_reg(2'd2, 16'h3);
        @(negedge clk);
        chk(wr_busy == 1'b1, "R9 still busy in last cycle", wr_busy, 1);
        wr_reg(2'd1, 16'h0777);
        chk(!wr_busy, "R5 request finished", wr_busy, 0);
        wr_reg(2'd0, 16'h161);
        wr_reg(2'd3, 16'h55); wr_reg(2'd3, 16'hAA); wr_reg(2'd2, 16'h3);
        wait_idle(b, s);
        for (int i = 2; i < 8; i++) do_word(16'h160 + i, 16'h0600 + i, 16'h3, b, s);
        chk(fm[16'h161] == 14'h0600, "R9 late data write dropped", fm[16'h161], 14'h0600);
        chk(!wr_err, "R9 no error", wr_err, 0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) fm[i] = BLANK;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_block();
        t_unlock();
        t_select();
        t_protect();
        t_order();
        t_busy_drop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule